// File: doc/BRIEF.md
# Directed-Rounding Mantissa Rounder

This unit rounds an unpacked floating-point mantissa that carries two extra low-order bits (guard and round) and a separate sticky flag. The unit shifts the two extra bits away and, depending on the rounding mode and the sign, adds one at the new least significant position. It reports whether it rounded up and whether the value was inexact. The carry out of the increment is passed on as its own output. Any exponent adjustment and renormalisation after that carry are left to the caller.

The same mode and sign inputs also select what an overflowing result becomes: infinity or the largest finite magnitude. The caller reads this decision whenever its own exponent check finds an overflow. All results are registered once, so they appear one clock after the inputs are applied. A new operand can be accepted every cycle.

Top module: `dir_round_unit`

## Requirements
- R1: The two lowest input bits, guard = `mant_i[1]` and round = `mant_i[0]`, are removed. When no increment is applied, `mant_o` equals `mant_i[MANT_W+1:2]` and `carry_o` is 0.
- R2: When guard, round and `sticky_i` are all zero, `round_up_o` and `inexact_o` are both 0, in every mode.
- R3: When any of guard, round or `sticky_i` is set, `inexact_o` is 1, in every mode.
- R4: In mode 0 (nearest), the value is incremented only if guard is 1 and at least one of round, sticky or the LSB of the shifted mantissa is 1. An exact tie therefore rounds to even.
- R5: In mode 1 (toward zero), the value is never incremented.
- R6: In mode 2 (toward +inf), an inexact value is incremented only when `sign_i` is 0. In mode 3 (toward -inf), an inexact value is incremented only when `sign_i` is 1.
- R7: An increment carries across the full mantissa width. An all-ones shifted mantissa becomes `mant_o` = 0 with `carry_o` = 1, and the block applies no correction.
- R8: `ovf_inf_o` depends only on mode and sign: it is 1 in mode 0, 0 in mode 1, `!sign_i` in mode 2 and `sign_i` in mode 3.
- R9: Every output is registered and appears one clock after its inputs. While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mant_i | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| sticky_i | input | 1 | OR of all bits below round |
| mode_i | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| mant_o | output | MANT_W | Rounded mantissa |
| carry_o | output | 1 | Carry out of the increment |
| round_up_o | output | 1 | Increment was applied |
| inexact_o | output | 1 | Guard, round or sticky was set |
| ovf_inf_o | output | 1 | Overflow goes to infinity (1) or to the largest finite value (0) |

## Verification
Every result (mantissa, carry, rounded-up, inexact and overflow target) is due exactly one rising edge after the operand is presented. Each scenario task drives its operand on a falling edge, waits for the next rising edge and samples 1 ns later, so every sample reads that single register stage. The expected values come from a wider-integer model in the bench, built from the mode rules, and are compared across ties, exact values, the full carry chain and random operands in all modes and signs.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      guard_i,
  input  logic      rbit_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      bump_o,
  output logic      inexact_o
);
  logic lost;
  assign lost      = guard_i | rbit_i | sticky_i;
  assign inexact_o = lost;

  always_comb begin
    bump_o = 1'b0;
    if (lost) begin
      unique case (mode_i)
        RM_ZERO: bump_o = 1'b0;
        RM_POS:  bump_o = ~sign_i;
        RM_NEG:  bump_o = sign_i;
        default: bump_o = guard_i & (rbit_i | sticky_i | lsb_i); // ties to even
      endcase
    end
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W = 24
) (
  input  logic [W-1:0] base_i,
  input  logic         bump_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W:0] c;
  assign c[0] = bump_i;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign sum_o[i] = base_i[i] ^ c[i];
    assign c[i+1]   = base_i[i] & c[i];
  end

  assign carry_o = c[W];
endmodule

// File: rtl/rnd_ovf.sv
module rnd_ovf
  import rnd_pkg::*;
(
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      to_inf_o
);
  always_comb begin
    unique case (mode_i)
      RM_ZERO: to_inf_o = 1'b0;
      RM_POS:  to_inf_o = ~sign_i;
      RM_NEG:  to_inf_o = sign_i;
      default: to_inf_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dir_round_unit.sv
module dir_round_unit
  import rnd_pkg::*;
#(
  parameter int MANT_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MANT_W+1:0] mant_i,
  input  logic              sign_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              carry_o,
  output logic              round_up_o,
  output logic              inexact_o,
  output logic              ovf_inf_o
);
  localparam int IN_W = MANT_W + 2;

  rnd_mode_e         mode;
  logic [MANT_W-1:0] base, sum;
  logic              bump, nx, cy, to_inf;

  assign mode = rnd_mode_e'(mode_i);
  assign base = mant_i[IN_W-1:2];

  rnd_decide u_decide (
    .guard_i  (mant_i[1]),
    .rbit_i   (mant_i[0]),
    .sticky_i (sticky_i),
    .lsb_i    (base[0]),
    .sign_i   (sign_i),
    .mode_i   (mode),
    .bump_o   (bump),
    .inexact_o(nx)
  );

  rnd_incr #(.W(MANT_W)) u_incr (
    .base_i (base),
    .bump_i (bump),
    .sum_o  (sum),
    .carry_o(cy)
  );

  rnd_ovf u_ovf (
    .sign_i  (sign_i),
    .mode_i  (mode),
    .to_inf_o(to_inf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_o     <= '0;
      carry_o    <= 1'b0;
      round_up_o <= 1'b0;
      inexact_o  <= 1'b0;
      ovf_inf_o  <= 1'b0;
    end else begin
      mant_o     <= sum;
      carry_o    <= cy;
      round_up_o <= bump;
      inexact_o  <= nx;
      ovf_inf_o  <= to_inf;
    end
  end
endmodule

// File: rtl/rnd_chk.sv
module rnd_chk #(
  parameter int MANT_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MANT_W+1:0] mant_i,
  input logic              sign_i,
  input logic              sticky_i,
  input logic [1:0]        mode_i,
  input logic [MANT_W-1:0] mant_o,
  input logic              carry_o,
  input logic              round_up_o,
  input logic              inexact_o,
  input logic              ovf_inf_o
);
  logic past_ok;
  logic lost;
  assign lost = mant_i[1] | mant_i[0] | sticky_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_KEEP_MANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !round_up_o) |-> (!carry_o && mant_o == $past(mant_i[MANT_W+1:2]))); // R1
  AST_BUMP_MANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && round_up_o) |->
      ({carry_o, mant_o} == (MANT_W+1)'($past(mant_i[MANT_W+1:2])) + (MANT_W+1)'(1))); // R7
  AST_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(lost)) |-> (!round_up_o && !inexact_o)); // R2
  AST_INEXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(lost)) |-> inexact_o); // R3
  AST_RTZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'd1) |-> !round_up_o); // R5
  AST_DIR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (($past(mode_i) == 2'd2 && $past(sign_i)) ||
                 ($past(mode_i) == 2'd3 && !$past(sign_i)))) |-> !round_up_o); // R6
  AST_OVF_NEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'd0) |-> ovf_inf_o); // R8
  AST_OVF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'd1) |-> !ovf_inf_o); // R8
endmodule

bind dir_round_unit rnd_chk #(.MANT_W(MANT_W)) u_chk (.*);

// File: tb/sim_dir_round_unit.sv
`timescale 1ns/1ps
module sim_dir_round_unit;
  localparam int MW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [MW+1:0] mant_i = '0;
  logic          sign_i = 1'b0;
  logic          sticky_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [MW-1:0] mant_o;
  logic          carry_o, round_up_o, inexact_o, ovf_inf_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  dir_round_unit #(.MANT_W(MW)) u0 (.*);

  // reference: result packed as {carry, mant, up, nx, inf}
  function automatic logic [MW+3:0] model(input logic [MW+1:0] m, input logic s,
                                          input logic st, input logic [1:0] md);
    logic          g, r, lost, up, inf;
    logic [MW:0]   sum;
    g = m[1]; r = m[0];
    lost = g | r | st;
    case (md)
      2'd1:    up = 1'b0;
      2'd2:    up = lost & !s;
      2'd3:    up = lost & s;
      default: up = g & (r | st | m[2]);
    endcase
    case (md)
      2'd1:    inf = 1'b0;
      2'd2:    inf = !s;
      2'd3:    inf = s;
      default: inf = 1'b1;
    endcase
    sum = {1'b0, m[MW+1:2]} + (MW+1)'(up);
    return {sum, up, lost, inf};
  endfunction

  task automatic apply(input string req, input logic [MW+1:0] m, input logic s,
                       input logic st, input logic [1:0] md);
    logic [MW+3:0] exp, got;
    @(negedge clk_i);
    mant_i = m; sign_i = s; sticky_i = st; mode_i = md;
    exp = model(m, s, st, md);
    @(posedge clk_i);
    #1;
    got = {carry_o, mant_o, round_up_o, inexact_o, ovf_inf_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: m=%h s=%0b st=%0b md=%0d got=%h exp=%h", req, m, s, st, md, got, exp);
    end
  endtask

  task automatic t_reset;
    checks++;
    if ({carry_o, mant_o, round_up_o, inexact_o, ovf_inf_o} !== '0) begin
      errors++;
      $display("FAIL R9: reset outputs got=%h exp=0",
               {carry_o, mant_o, round_up_o, inexact_o, ovf_inf_o});
    end
  endtask

  task automatic t_exact;
    for (int md = 0; md < 4; md++) begin
      apply("R2", 26'h1234568, 1'b1, 1'b0, 2'(md));
      apply("R1", 26'h2ABCDE0, 1'b0, 1'b0, 2'(md));
    end
  endtask

  task automatic t_nearest;
    apply("R4 tie even", 26'h0000012, 1'b0, 1'b0, 2'd0);
    apply("R4 tie odd",  26'h0000016, 1'b0, 1'b0, 2'd0);
    apply("R4 above",    26'h0000013, 1'b0, 1'b0, 2'd0);
    apply("R4 sticky",   26'h0000012, 1'b1, 1'b1, 2'd0);
    apply("R4 below",    26'h0000015, 1'b0, 1'b1, 2'd0);
  endtask

  task automatic t_zero;
    apply("R5", 26'h0000017, 1'b0, 1'b1, 2'd1);
    apply("R5", 26'h3FFFFFF, 1'b1, 1'b1, 2'd1);
  endtask

  task automatic t_directed;
    apply("R6 pos up",  26'h0000101, 1'b0, 1'b0, 2'd2);
    apply("R6 pos neg", 26'h0000101, 1'b1, 1'b0, 2'd2);
    apply("R6 neg up",  26'h0000100, 1'b1, 1'b1, 2'd3);
    apply("R6 neg pos", 26'h0000100, 1'b0, 1'b1, 2'd3);
    apply("R3 sticky",  26'h0000100, 1'b0, 1'b1, 2'd1);
  endtask

  task automatic t_carry;
    apply("R7 near", 26'h3FFFFFF, 1'b0, 1'b0, 2'd0);
    apply("R7 pos",  26'h3FFFFFD, 1'b0, 1'b0, 2'd2);
    apply("R7 neg",  26'h3FFFFFC, 1'b1, 1'b1, 2'd3);
  endtask

  task automatic t_overflow;
    for (int md = 0; md < 4; md++)
      for (int s = 0; s < 2; s++)
        apply("R8", 26'h0000000, 1'(s), 1'b0, 2'(md));
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++)
      apply("R4 R6 random", 26'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_exact();
    t_nearest();
    t_zero();
    t_directed();
    t_carry();
    t_overflow();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule